// File: doc/BRIEF.md
# Programmable five-flag FIFO status generator

This block keeps the occupancy of a 512-word FIFO from its write and read strobes and derives five status flags from it: empty, almost-empty, half-full, almost-full and full. It holds no data. It sits beside the storage array, in the same clock domain, and tells the logic on both sides how much room or content remains.

Two thresholds are set through a small register port: the almost-empty offset and the almost-full offset. A third register holds one timing bit per flag. A clear bit makes the flag follow the occupancy counter directly, so it changes in the cycle after the strobe edge. A set bit passes the flag through one more flip-flop, so it changes one cycle later. No programming is needed after reset. Both offsets start at 8 and all five flags start in the direct mode.

Top module: `fifo_flag_gen`

## Requirements
- R1: After a synchronous reset (rst high at a rising edge) the occupancy is 0, both offsets are 8 and all mode bits are 0. The flags then read empty=1, almost-empty=1, half-full=0, almost-full=0 and full=0.
- R2: flag_empty is high exactly when the occupancy is 0.
- R3: flag_full is high exactly when the occupancy is 512. The occupancy never exceeds 512.
- R4: flag_half is high exactly when the occupancy is greater than 256.
- R5: flag_aempty is high when the occupancy is less than or equal to the almost-empty offset.
- R6: flag_afull is high when the free space (512 minus the occupancy) is less than or equal to the almost-full offset.
- R7: A write while the occupancy is 512 and a read while the occupancy is 0 are both ignored. If both strobes are high at full, only the read takes effect; if both are high at empty, only the write takes effect.
- R8: When a write and a read are both accepted in the same cycle, the occupancy does not change.
- R9: The mode register has one bit per flag: bit 0 empty, bit 1 almost-empty, bit 2 half-full, bit 3 almost-full, bit 4 full. With the bit at 0 the flag reflects the occupancy and offsets as they stand after the current edge. With the bit at 1 the flag shows the value it would have had in direct mode one cycle earlier.
- R10: A write with cfg_we high at a rising edge loads cfg_wdata into a register chosen by cfg_addr: 0 loads the almost-empty offset, 1 loads the almost-full offset, 2 loads the mode register from cfg_wdata[4:0], and 3 changes nothing. The new value takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe of the FIFO |
| rd_en | input | 1 | Read strobe of the FIFO |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select: 0 almost-empty offset, 1 almost-full offset, 2 mode |
| cfg_wdata | input | 9 | Register write data |
| flag_empty | output | 1 | Occupancy is zero |
| flag_aempty | output | 1 | Occupancy is at or below the almost-empty offset |
| flag_half | output | 1 | Occupancy is above half the depth |
| flag_afull | output | 1 | Free space is at or below the almost-full offset |
| flag_full | output | 1 | Occupancy equals the depth |

## Verification
The counter and the register port are each one flop deep. A flag in direct mode therefore shows the effect of a strobe or a register write in the first cycle after the edge that sampled it, and a flag in registered mode shows it one cycle after that. The bench drives inputs on the falling edge. At each rising edge it updates a behavioural occupancy and register model, and it keeps the flag values implied by the state before that edge. Half a cycle later it compares every flag against either the new value or the kept one, depending on that flag's mode bit in the model.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;
  localparam int NFLAG = 5;
  localparam int IDX_EMPTY  = 0;
  localparam int IDX_AEMPTY = 1;
  localparam int IDX_HALF   = 2;
  localparam int IDX_AFULL  = 3;
  localparam int IDX_FULL   = 4;

  localparam logic [1:0] ADDR_AE_OFF = 2'd0;
  localparam logic [1:0] ADDR_AF_OFF = 2'd1;
  localparam logic [1:0] ADDR_MODE   = 2'd2;

  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/fifo_flag_count.sv
module fifo_flag_count #(
  parameter int DEPTH = 512,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL_V = CW'(DEPTH);

  logic wr_ok;
  logic rd_ok;

  assign wr_ok = wr_en && (count != FULL_V);
  assign rd_ok = rd_en && (count != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (wr_ok && !rd_ok) begin
      count <= count + 1'b1;
    end else if (rd_ok && !wr_ok) begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/fifo_flag_cfg.sv
module fifo_flag_cfg
  import fifo_flag_pkg::*;
#(
  parameter int OW      = 9,
  parameter int DEF_OFF = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [OW-1:0] cfg_wdata,
  output logic [OW-1:0] ae_off,
  output logic [OW-1:0] af_off,
  output flag_vec_t     mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ae_off <= OW'(DEF_OFF);
      af_off <= OW'(DEF_OFF);
      mode   <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        ADDR_AE_OFF: ae_off <= cfg_wdata;
        ADDR_AF_OFF: af_off <= cfg_wdata;
        ADDR_MODE:   mode   <= cfg_wdata[NFLAG-1:0];
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/fifo_flag_eval.sv
module fifo_flag_eval
  import fifo_flag_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int CW    = $clog2(DEPTH) + 1,
  parameter int OW    = $clog2(DEPTH)
) (
  input  logic [CW-1:0] count,
  input  logic [OW-1:0] ae_off,
  input  logic [OW-1:0] af_off,
  output flag_vec_t     flag_now
);
  localparam logic [CW-1:0] FULL_V = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_V = CW'(DEPTH / 2);

  logic [CW-1:0] space;

  always_comb begin
    space = FULL_V - count;
    flag_now[IDX_EMPTY]  = (count == '0);
    flag_now[IDX_AEMPTY] = (count <= CW'(ae_off));
    flag_now[IDX_HALF]   = (count > HALF_V);
    flag_now[IDX_AFULL]  = (space <= CW'(af_off));
    flag_now[IDX_FULL]   = (count == FULL_V);
  end
endmodule

// File: rtl/fifo_flag_out.sv
module fifo_flag_out
  import fifo_flag_pkg::*;
#(
  parameter flag_vec_t RST_VEC = '0
) (
  input  logic      clk,
  input  logic      rst,
  input  flag_vec_t flag_now,
  input  flag_vec_t mode,
  output flag_vec_t flag_out
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (rst) q <= RST_VEC[i];
      else     q <= flag_now[i];
    end
    assign flag_out[i] = mode[i] ? q : flag_now[i];
  end
endmodule

// File: rtl/fifo_flag_gen.sv
module fifo_flag_gen
  import fifo_flag_pkg::*;
#(
  parameter int DEPTH   = 512,
  parameter int DEF_OFF = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_addr,
  input  logic [$clog2(DEPTH)-1:0] cfg_wdata,
  output logic                     flag_empty,
  output logic                     flag_aempty,
  output logic                     flag_half,
  output logic                     flag_afull,
  output logic                     flag_full
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam int OW = $clog2(DEPTH);
  localparam flag_vec_t RST_VEC = {1'b0, (DEPTH <= DEF_OFF), 1'b0, 1'b1, 1'b1};

  logic [CW-1:0] count;
  logic [OW-1:0] ae_off;
  logic [OW-1:0] af_off;
  flag_vec_t     mode;
  flag_vec_t     flag_now;
  flag_vec_t     flag_out;

  fifo_flag_count #(.DEPTH(DEPTH), .CW(CW)) u_count (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .count(count)
  );

  fifo_flag_cfg #(.OW(OW), .DEF_OFF(DEF_OFF)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ae_off(ae_off), .af_off(af_off), .mode(mode)
  );

  fifo_flag_eval #(.DEPTH(DEPTH), .CW(CW), .OW(OW)) u_eval (
    .count(count), .ae_off(ae_off), .af_off(af_off), .flag_now(flag_now)
  );

  fifo_flag_out #(.RST_VEC(RST_VEC)) u_out (
    .clk(clk), .rst(rst), .flag_now(flag_now), .mode(mode), .flag_out(flag_out)
  );

  assign flag_empty  = flag_out[IDX_EMPTY];
  assign flag_aempty = flag_out[IDX_AEMPTY];
  assign flag_half   = flag_out[IDX_HALF];
  assign flag_afull  = flag_out[IDX_AFULL];
  assign flag_full   = flag_out[IDX_FULL];
endmodule

// File: rtl/fifo_flag_chk.sv
module fifo_flag_chk
  import fifo_flag_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic [CW-1:0] count,
  input flag_vec_t     flag_now,
  input flag_vec_t     mode,
  input flag_vec_t     flags_o
);
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R7
  full_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH) && wr_en && !rd_en) |=> $stable(count));

  // R7
  empty_read_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && rd_en && !wr_en) |=> $stable(count));

  // R8
  both_strobes_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && count != '0 && count != CW'(DEPTH)) |=> $stable(count));

  // R2
  empty_direct_chk: assert property (@(posedge clk) disable iff (rst)
    !mode[IDX_EMPTY] |-> (flags_o[IDX_EMPTY] == (count == '0)));

  for (genvar i = 0; i < NFLAG; i++) begin : g_mode
    // R9
    reg_mode_delay_chk: assert property (@(posedge clk) disable iff (rst)
      mode[i] |-> (flags_o[i] == $past(flag_now[i])));
  end
endmodule

bind fifo_flag_gen fifo_flag_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .count(count),
  .flag_now(flag_now), .mode(mode), .flags_o(flag_out)
);

// File: tb/fifo_flag_gen_test.sv
module fifo_flag_gen_test;
  localparam int DEPTH = 512;
  localparam int OW    = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = 2'd0;
  logic [OW-1:0] cfg_wdata = '0;
  logic flag_empty, flag_aempty, flag_half, flag_afull, flag_full;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  int m_cnt, m_ae, m_af;
  logic [4:0] m_mode;

  always #10 clk = ~clk;

  fifo_flag_gen uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .flag_empty(flag_empty),
    .flag_aempty(flag_aempty), .flag_half(flag_half), .flag_afull(flag_afull),
    .flag_full(flag_full)
  );

  function automatic logic [4:0] ref_flags(int c, int a, int b);
    logic [4:0] f;
    f[0] = (c == 0);
    f[1] = (c <= a);
    f[2] = (c > DEPTH / 2);
    f[3] = ((DEPTH - c) <= b);
    f[4] = (c == DEPTH);
    return f;
  endfunction

  function automatic logic [4:0] dut_flags();
    return {flag_full, flag_afull, flag_half, flag_aempty, flag_empty};
  endfunction

  task automatic check(logic [4:0] exp, string tag);
    tests++;
    if (dut_flags() !== exp) begin
      fails++;
      $display("FAIL %s: flags {full,afull,half,aempty,empty} actual %b expected %b (occupancy %0d)",
               tag, dut_flags(), exp, m_cnt);
    end
  endtask

  // One cycle: inputs applied now (after a falling edge), model stepped at the rising edge,
  // outputs compared at the next falling edge.
  task automatic tick(bit w, bit r, bit cwe, logic [1:0] ca, int cd, string tag);
    logic [4:0] f_old, f_new, exp;
    bit wok, rok;
    wr_en = w; rd_en = r; cfg_we = cwe; cfg_addr = ca; cfg_wdata = OW'(cd);
    @(posedge clk);
    f_old = ref_flags(m_cnt, m_ae, m_af);
    wok = w && (m_cnt != DEPTH);
    rok = r && (m_cnt != 0);
    if (wok && !rok) m_cnt++;
    else if (rok && !wok) m_cnt--;
    if (cwe) begin
      case (ca)
        2'd0: m_ae = cd;
        2'd1: m_af = cd;
        2'd2: m_mode = cd[4:0];
        default: ;
      endcase
    end
    f_new = ref_flags(m_cnt, m_ae, m_af);
    for (int i = 0; i < 5; i++) exp[i] = m_mode[i] ? f_old[i] : f_new[i];
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; cfg_we = 1'b0;
    check(exp, tag);
  endtask

  task automatic cfg(logic [1:0] ca, int cd, string tag);
    tick(1'b0, 1'b0, 1'b1, ca, cd, tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    m_cnt = 0; m_ae = 8; m_af = 8; m_mode = '0;
    @(negedge clk);
    rst = 1'b0;
    check(5'b00011, "R1 reset state");
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    tick(1'b0, 1'b0, 1'b0, 2'd0, 0, "R1 idle after reset");

    // fill in direct mode
    for (int i = 0; i < 12; i++) tick(1'b1, 1'b0, 1'b0, 2'd0, 0, "R5 almost-empty edge");
    for (int i = 0; i < 290; i++) tick(1'b1, 1'b0, 1'b0, 2'd0, 0, "R4 half crossing");
    for (int i = 0; i < 210; i++) tick(1'b1, 1'b0, 1'b0, 2'd0, 0, "R6 almost-full edge");
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, 1'b0, 2'd0, 0, "R3 write at full");
    tick(1'b1, 1'b1, 1'b0, 2'd0, 0, "R7 both strobes at full");
    tick(1'b1, 1'b0, 1'b0, 2'd0, 0, "R3 refill");
    tick(1'b1, 1'b0, 1'b0, 2'd0, 0, "R7 write ignored at full");
    for (int i = 0; i < 20; i++) tick(1'b1, 1'b1, 1'b0, 2'd0, 0, "R8 both strobes mid");

    // drain
    for (int i = 0; i < 515; i++) tick(1'b0, 1'b1, 1'b0, 2'd0, 0, "R2 drain to empty");
    tick(1'b0, 1'b1, 1'b0, 2'd0, 0, "R7 read ignored at empty");
    tick(1'b1, 1'b1, 1'b0, 2'd0, 0, "R7 both strobes at empty");
    tick(1'b0, 1'b1, 1'b0, 2'd0, 0, "R2 back to empty");

    // program offsets
    cfg(2'd0, 100, "R10 almost-empty offset");
    cfg(2'd1, 50, "R10 almost-full offset");
    cfg(2'd3, 7, "R10 unused address");
    for (int i = 0; i < 120; i++) tick(1'b1, 1'b0, 1'b0, 2'd0, 0, "R5 programmed offset");
    for (int i = 0; i < 10; i++) tick(1'b1, 1'b0, 1'b0, 2'd0, 0, "R10 offset live");

    // registered mode for all flags
    cfg(2'd2, 31, "R9 all registered");
    for (int i = 0; i < 400; i++) tick(1'b1, 1'b0, 1'b0, 2'd0, 0, "R9 fill registered");
    for (int i = 0; i < 30; i++) tick(i[0], !i[0], 1'b0, 2'd0, 0, "R9 toggle near full");
    for (int i = 0; i < 530; i++) tick(1'b0, 1'b1, 1'b0, 2'd0, 0, "R9 drain registered");

    // mixed modes and extreme offsets
    cfg(2'd2, 5'b01010, "R9 mixed modes");
    cfg(2'd0, 0, "R10 zero almost-empty offset");
    cfg(2'd1, 511, "R10 max almost-full offset");
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 1'b0, 2'd0, 0, "R6 max offset");
    cfg(2'd1, 0, "R10 zero almost-full offset");
    for (int i = 0; i < 510; i++) tick(1'b1, 1'b0, 1'b0, 2'd0, 0, "R6 zero offset");
    cfg(2'd2, 5'b10101, "R9 swap modes");
    for (int i = 0; i < 6; i++) tick(1'b1, (i % 3) == 0, 1'b0, 2'd0, 0, "R3 mixed at top");
    for (int i = 0; i < 40; i++) tick(1'b0, 1'b1, 1'b1, 2'd0, i * 5, "R10 offset change while reading");

    // reset again from a non-default state
    do_reset();
    tick(1'b1, 1'b0, 1'b0, 2'd0, 0, "R1 defaults after second reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule